// File: doc/BRIEF.md
# SPI Slave Memory-Bus Bridge

This block lets an SPI master reach a passive parallel device, such as a small memory or a display driver, through a simple address/data bus. Every transfer starts when slave select goes low. The first serial word carries the start address. After it arrives, the bridge reads the device at that address and queues the result for the serial output. Each later word is exchanged in both directions at once. When a word has been fully received, the bridge writes it to the current address, moves to the next address, and reads ahead again so the following word can be sent back.

The serial clock is oversampled by the system clock. The serial lines pass through two-flop synchronizers, and shift and sample moments are found from the synchronized clock level. Two static pins select the clock polarity and phase. Address and data widths are parameters. Words travel most significant bit first. The device's read data is expected on `data_in` during the cycle in which `rd` is high.

Top module: `spi_mem_bridge`

## Requirements
- R1: While reset is asserted and just after it is released, `rd`, `we` and `so` are 0, and `addr_out` and `data_out` are all zeros.
- R2: The first ADDR_W bits sampled after `ss` falls, most significant first, appear on `addr_out`, together with a one-cycle `rd` pulse at that address.
- R3: The value on `data_in` during an `rd` pulse is the next data word shifted out on `so`, most significant bit first.
- R4: `so` is 0 during the address word and while `ss` is high.
- R5: Each complete data word of DATA_W bits produces exactly one one-cycle `we` pulse. During that pulse, `data_out` holds the received word and `addr_out` holds the current address.
- R6: The cycle after each `we` pulse, `addr_out` has advanced by one (modulo 2^ADDR_W) and `rd` pulses at the new address.
- R7: All four settings of `cpol` (idle level of `sck`) and `cpha` (0: sample on the first edge of each bit; 1: sample on the second edge) transfer data correctly.
- R8: If `ss` rises partway through a word, that word is dropped: no `we` and no `rd` result from it, and the next transfer starts again with an address word.
- R9: `rd` and `we` are never high in the same cycle, and each pulse lasts exactly one cycle.
- R10: The receive and write path works with `sck` at one quarter of the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| ss | input | 1 | Active-low slave select |
| data_in | input | DATA_W | Read data from the passive device |
| data_out | output | DATA_W | Write data to the passive device |
| addr_out | output | ADDR_W | Device address |
| rd | output | 1 | One-cycle read strobe |
| we | output | 1 | One-cycle write strobe |
| so | output | 1 | Serial data to the master |

## Verification
A wrong bit counter or phase would show up at the end of the first word. The address would land on the wrong bits, or a `we` pulse would carry a shifted value, and both are visible within one word time. A wrong transmit load or skip flag corrupts the word the master reads back on `so`. The bench compares that word bit for bit at the end of each word. Faults in the strobe or increment logic show within one or two cycles after a word ends, because the bench holds a queue of expected strobe addresses and data and checks them on every clock.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_edge_detect.sv
module spi_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cpol,
  input  logic cpha,
  input  logic sck,
  input  logic si,
  input  logic ss,
  output logic sample_o,
  output logic shift_o,
  output logic si_o,
  output logic ss_fall_o,
  output logic ss_rise_o
);
  logic [2:0] sck_q;
  logic [1:0] si_q;
  logic [2:0] ss_q;
  logic       rise, fall, lead, trail, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      si_q  <= '0;
      ss_q  <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
      ss_q  <= {ss_q[1:0], ss};
    end
  end

  always_comb begin
    rise      = sck_q[1] & ~sck_q[2];
    fall      = ~sck_q[1] & sck_q[2];
    lead      = cpol ? fall : rise;
    trail     = cpol ? rise : fall;
    active    = ~ss_q[1];
    sample_o  = active & (cpha ? trail : lead);
    shift_o   = active & (cpha ? lead : trail);
    si_o      = si_q[1];
    ss_fall_o = ~ss_q[1] & ss_q[2];
    ss_rise_o = ss_q[1] & ~ss_q[2];
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int RX_W = 8,
  parameter int TX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            skip_init,
  input  logic            arm_skip,
  input  logic            sample,
  input  logic            shift,
  input  logic            si,
  input  logic            load,
  input  logic [TX_W-1:0] load_data,
  output logic [RX_W-1:0] rx_o,
  output logic            so_o
);
  logic [RX_W-1:0] rx_q, rx_n;
  logic [TX_W-1:0] tx_q, tx_n;
  logic            skip_q, skip_n;

  always_comb begin
    rx_n   = rx_q;
    tx_n   = tx_q;
    skip_n = skip_q;
    if (sample) rx_n = {rx_q[RX_W-2:0], si};
    if (clear) begin
      tx_n   = '0;
      skip_n = skip_init;
    end else if (load) begin
      tx_n = load_data;
      if (shift) skip_n = 1'b0;
    end else if (shift) begin
      if (skip_q) skip_n = 1'b0;
      else        tx_n   = {tx_q[TX_W-2:0], 1'b0};
    end
    if (arm_skip && !clear) skip_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      skip_q <= 1'b0;
    end else begin
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      skip_q <= skip_n;
    end
  end

  assign rx_o = rx_q;
  assign so_o = tx_q[TX_W-1];
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RX_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic [RX_W-1:0]   rx,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              rd_o,
  output logic              we_o,
  output logic              word_done_o
);
  localparam int CNT_W = $clog2(RX_W) + 1;
  localparam logic [CNT_W-1:0] ALAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DLAST = CNT_W'(DATA_W - 1);

  phase_t            phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, last;
  logic              done_q, done_n, dadr_q, dadr_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] dout_q, dout_n;
  logic              rd_q, rd_n, we_q, we_n;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    dadr_n  = dadr_q;
    addr_n  = addr_q;
    dout_n  = dout_q;
    rd_n    = 1'b0;
    we_n    = 1'b0;
    last    = (phase_q == PH_ADDR) ? ALAST : DLAST;
    if (ss_fall) begin
      phase_n = PH_ADDR;
      cnt_n   = '0;
    end else if (ss_rise) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
    end else if (sample && phase_q != PH_IDLE) begin
      if (cnt_q == last) begin
        cnt_n   = '0;
        done_n  = 1'b1;
        dadr_n  = (phase_q == PH_ADDR);
        phase_n = PH_DATA;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    if (done_q) begin
      if (dadr_q) begin
        addr_n = rx[ADDR_W-1:0];
        rd_n   = 1'b1;
      end else begin
        dout_n = rx[DATA_W-1:0];
        we_n   = 1'b1;
      end
    end
    if (we_q) begin
      addr_n = addr_q + 1'b1;
      rd_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      dadr_q  <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
      rd_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      done_q  <= done_n;
      dadr_q  <= dadr_n;
      addr_q  <= addr_n;
      dout_q  <= dout_n;
      rd_q    <= rd_n;
      we_q    <= we_n;
    end
  end

  assign addr_o      = addr_q;
  assign dout_o      = dout_q;
  assign rd_o        = rd_q;
  assign we_o        = we_q;
  assign word_done_o = done_q;
endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck,
  input  logic              si,
  input  logic              ss,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              rd,
  output logic              we,
  output logic              so
);
  localparam int RX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

  logic            sample, shift, si_s, ss_fall, ss_rise, word_done;
  logic [RX_W-1:0] rx;

  spi_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
    .sck(sck), .si(si), .ss(ss),
    .sample_o(sample), .shift_o(shift), .si_o(si_s),
    .ss_fall_o(ss_fall), .ss_rise_o(ss_rise)
  );

  spi_shift_unit #(.RX_W(RX_W), .TX_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clear(ss_fall | ss_rise), .skip_init(cpha), .arm_skip(word_done),
    .sample(sample), .shift(shift), .si(si_s),
    .load(rd), .load_data(data_in),
    .rx_o(rx), .so_o(so)
  );

  spi_xfer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RX_W(RX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sample(sample),
    .ss_fall(ss_fall), .ss_rise(ss_rise), .rx(rx),
    .addr_o(addr_out), .dout_o(data_out),
    .rd_o(rd), .we_o(we), .word_done_o(word_done)
  );
endmodule

// File: rtl/spi_mem_bridge_chk.sv
module spi_mem_bridge_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss,
  input logic              so,
  input logic              rd,
  input logic              we,
  input logic [ADDR_W-1:0] addr_out
);
  a_r9_rd_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && we));

  a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rd);

  a_r9_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (addr_out == $past(addr_out) + ADDR_W'(1)));

  a_r6_read_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rd);

  a_r4_so_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ss && $past(ss) && $past(ss, 2) && $past(ss, 3) && $past(ss, 4)) |-> !so);
endmodule

bind spi_mem_bridge spi_mem_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss(ss), .so(so), .rd(rd), .we(we), .addr_out(addr_out)
);

// File: tb/spi_mem_bridge_tb.sv
module spi_mem_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0, sck = 1'b0, si = 1'b0, ss = 1'b1;
  logic [7:0] data_in, data_out, addr_out;
  logic       rd, we, so;

  logic [7:0] mem [256];
  logic [7:0] wbuf [8];
  logic [7:0] exp_rd_q [$];
  logic [15:0] exp_we_q [$];
  int checks = 0, fails = 0, cycles = 0, ss_hi = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_mem_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sck(sck), .si(si),
    .ss(ss), .data_in(data_in), .data_out(data_out), .addr_out(addr_out),
    .rd(rd), .we(we), .so(so)
  );

  assign data_in = mem[addr_out];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // per-clock reference: the passive device and the expected strobe queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd && we) chk(1'b0, "R9 rd/we overlap", 1, 0);
      if (rd) begin
        if (exp_rd_q.size() == 0) chk(1'b0, "R8 unexpected rd", addr_out, 0);
        else begin
          logic [7:0] ea;
          ea = exp_rd_q.pop_front();
          chk(addr_out == ea, "R2/R6 rd address", addr_out, ea);
        end
      end
      if (we) begin
        if (exp_we_q.size() == 0) chk(1'b0, "R8 unexpected we", addr_out, 0);
        else begin
          logic [15:0] e;
          e = exp_we_q.pop_front();
          chk(addr_out == e[15:8], "R5 we address", addr_out, e[15:8]);
          chk(data_out == e[7:0], "R5 we data", data_out, e[7:0]);
          mem[addr_out] = data_out;
        end
      end
      ss_hi = ss ? ss_hi + 1 : 0;
      if (ss_hi > 5 && so) chk(1'b0, "R4 so idle", so, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  task automatic send_bits(input logic [7:0] v, input int n, input int h,
                           output logic [7:0] got);
    got = '0;
    for (int b = 7; b > 7 - n; b--) begin
      if (!cpha) begin
        si = v[b];
        repeat (h) @(negedge clk);
        got = {got[6:0], so};
        sck = ~cpol;
        repeat (h) @(negedge clk);
        sck = cpol;
      end else begin
        sck = ~cpol;
        si = v[b];
        repeat (h) @(negedge clk);
        got = {got[6:0], so};
        sck = cpol;
        repeat (h) @(negedge clk);
      end
    end
  endtask

  task automatic xfer(input logic pol, input logic pha, input int h,
                      input logic [7:0] a, input int nfull, input int pbits,
                      input bit miso_chk, input string tag);
    logic [7:0] exp_miso [8];
    logic [7:0] got;
    for (int i = 0; i <= nfull && i < 8; i++) exp_miso[i] = mem[8'(a + i)];
    exp_rd_q.push_back(a);
    for (int i = 0; i < nfull; i++) begin
      exp_we_q.push_back({8'(a + i), wbuf[i]});
      exp_rd_q.push_back(8'(a + i + 1));
    end
    cpol = pol; cpha = pha; sck = pol;
    repeat (8) @(negedge clk);
    ss = 1'b0;
    repeat (h) @(negedge clk);
    send_bits(a, 8, h, got);
    if (miso_chk) chk(got == 8'h00, {"R4 addr-word so ", tag}, got, 0);
    for (int w = 0; w < nfull; w++) begin
      send_bits(wbuf[w], 8, h, got);
      if (miso_chk) chk(got == exp_miso[w], {"R3 read data ", tag}, got, exp_miso[w]);
    end
    if (pbits > 0) send_bits(8'hA5, pbits, h, got);
    repeat (h) @(negedge clk);
    ss = 1'b1;
    repeat (16) @(negedge clk);
    chk(exp_rd_q.size() == 0, {"R6/R8 rd count ", tag}, exp_rd_q.size(), 0);
    chk(exp_we_q.size() == 0, {"R5/R8 we count ", tag}, exp_we_q.size(), 0);
    exp_rd_q.delete();
    exp_we_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    chk(!rd && !we && !so, "R1 strobes in reset", {rd, we, so}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_out == 0 && data_out == 0, "R1 buses after reset", {addr_out, data_out}, 0);
    chk(!rd && !we && !so, "R1 strobes after reset", {rd, we, so}, 0);

    // R7: all four modes, R2/R3/R5/R6 along the way
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA1; wbuf[2] = 8'h7E;
    xfer(1'b0, 1'b0, 8, 8'h10, 3, 0, 1'b1, "R7 mode0");
    wbuf[0] = 8'h55; wbuf[1] = 8'h80;
    xfer(1'b0, 1'b1, 8, 8'h40, 2, 0, 1'b1, "R7 mode1");
    wbuf[0] = 8'hFF; wbuf[1] = 8'h01; wbuf[2] = 8'hC3;
    xfer(1'b1, 1'b0, 8, 8'h80, 3, 0, 1'b1, "R7 mode2");
    wbuf[0] = 8'h00; wbuf[1] = 8'h9B;
    xfer(1'b1, 1'b1, 8, 8'hC0, 2, 0, 1'b1, "R7 mode3");

    // read back what mode 0 wrote: R3 through a second transfer
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    xfer(1'b0, 1'b0, 8, 8'h10, 2, 0, 1'b1, "R3 readback");
    chk(mem[8'h10] == 8'h11 && mem[8'h12] == 8'h7E, "R5 device contents",
        mem[8'h12], 8'h7E);

    // R6: address wraps modulo 2^ADDR_W
    wbuf[0] = 8'hDE; wbuf[1] = 8'hAD;
    xfer(1'b1, 1'b1, 8, 8'hFF, 2, 0, 1'b1, "R6 wrap");
    chk(mem[8'hFF] == 8'hDE && mem[8'h00] == 8'hAD, "R6 wrap contents",
        mem[8'h00], 8'hAD);

    // R8: slave select rises mid data word, and mid address word
    wbuf[0] = 8'h66;
    xfer(1'b0, 1'b0, 8, 8'h20, 1, 3, 1'b1, "R8 partial data");
    chk(mem[8'h21] == 8'(8'h21 * 37 + 11), "R8 untouched", mem[8'h21],
        8'(8'h21 * 37 + 11));
    cpol = 1'b0; cpha = 1'b0; sck = 1'b0;
    repeat (8) @(negedge clk);
    ss = 1'b0;
    begin
      logic [7:0] g;
      send_bits(8'h30, 5, 8, g);
    end
    ss = 1'b1;
    repeat (16) @(negedge clk);
    chk(addr_out == 8'h21, "R8 partial addr ignored", addr_out, 8'h21);
    wbuf[0] = 8'h77;
    xfer(1'b0, 1'b1, 8, 8'h50, 1, 0, 1'b1, "R8 fresh start");

    // R10: write path at sck = clk/4
    wbuf[0] = 8'hB4; wbuf[1] = 8'h4B; wbuf[2] = 8'hE7;
    xfer(1'b0, 1'b0, 2, 8'h60, 3, 0, 1'b0, "R10 fast");
    chk(mem[8'h62] == 8'hE7, "R10 fast contents", mem[8'h62], 8'hE7);

    summary();
  end
endmodule